// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides which received CAN frames reach the host. The receive path delivers a finished identifier as four bytes plus an extended-format flag, together with a one-cycle end-of-frame strobe. Every such frame is first copied into a background slot. The identifier is then compared against programmable code and mask bytes, held in two banks. A frame that passes either bank is promoted to a foreground slot, and a ready flag is raised for the host. A frame that fails is never reported, and the next frame overwrites its background slot.

The code and mask bytes sit behind a small byte-wide register port. They can be read at any time. They can be written only while the initialization request and the initialization acknowledge are both high. The accept or drop outcome appears one clock after the strobe. The host consumes a frame with a single acknowledge pulse.

Top module: `can_id_screen`

## Requirements
- R1: After reset, all sixteen code and mask bytes read as zero, and the ready, overrun and decision-valid outputs are low.
- R2: A register write takes effect only while init_req and init_ack are both 1. A write at any other time leaves the register unchanged. The address map is as follows. Addresses 0..3 hold the bank 0 code for identifier bytes 0..3, and addresses 4..7 hold the bank 1 code. Addresses 8..11 hold the bank 0 mask, and addresses 12..15 hold the bank 1 mask.
- R3: cfg_rdata shows the byte at cfg_addr combinationally, whatever the state of init_req and init_ack.
- R4: On the clock after every end-of-frame strobe, bg_id/bg_ide hold that frame's identifier, whether the frame was accepted or dropped.
- R5: rx_id[31:24] is identifier byte 0 and rx_id[7:0] is byte 3. A mask bit of 1 makes the matching identifier bit a don't-care. A mask bit of 0 requires the identifier bit to equal the code bit.
- R6: For a frame with rx_ide=1, all four identifier bytes take part in the compare.
- R7: For a frame with rx_ide=0, only identifier bytes 0 and 1 take part in the compare. Bytes 2 and 3 have no effect on the outcome.
- R8: A frame is accepted if it matches either bank. fg_bank gives the matching bank. When both banks match, bank 0 is reported.
- R9: dec_valid is high for exactly the one clock after each strobe, and dec_accept gives the outcome during that clock.
- R10: An accepted frame arriving while rx_ready is low loads fg_id/fg_ide/fg_bank and sets rx_ready. A dropped frame changes neither rx_ready nor the foreground slot.
- R11: rx_ready stays set until host_ack. An accepted frame arriving while rx_ready is set (and host_ack is low) leaves the foreground slot unchanged and sets rx_overrun.
- R12: host_ack clears rx_ready and rx_overrun. If an accepted frame's strobe coincides with host_ack, that frame is loaded, rx_ready stays 1 and rx_overrun ends 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register byte address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |
| init_req | input | 1 | Initialization request |
| init_ack | input | 1 | Initialization acknowledge |
| rx_eof | input | 1 | End-of-frame strobe, one cycle |
| rx_ide | input | 1 | 1 = extended identifier frame |
| rx_id | input | 32 | Identifier bytes 0..3, byte 0 in the top bits |
| host_ack | input | 1 | Host consumed the foreground frame |
| bg_id | output | 32 | Background slot identifier |
| bg_ide | output | 1 | Background slot format flag |
| fg_id | output | 32 | Foreground slot identifier |
| fg_ide | output | 1 | Foreground slot format flag |
| fg_bank | output | 1 | Bank that accepted the foreground frame |
| rx_ready | output | 1 | Accepted frame waiting for the host |
| rx_overrun | output | 1 | An accepted frame was lost while ready was set |
| dec_valid | output | 1 | Decision strobe, one clock after rx_eof |
| dec_accept | output | 1 | Decision outcome |

## Verification
The hardest situation to reach from the ports is a host acknowledge that falls in the same clock as the strobe of an accepted frame. In that clock the clear and the load compete. The bench reaches it by first leaving a frame unacknowledged and then raising host_ack together with rx_eof. The overrun case needs a second accepted frame with no acknowledge between the two. The tie between banks needs one bank's mask reprogrammed to all ones, so the bench returns to initialization mode partway through the run.

// File: rtl/idscr_pkg.sv
package idscr_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      OUT_IDLE    = 2'd0,
      OUT_DROP    = 2'd1,
      OUT_TAKE    = 2'd2,
      OUT_OVERRUN = 2'd3
   } outcome_e;
endpackage

// File: rtl/idscr_regs.sv
module idscr_regs
   import idscr_pkg::*;
#(
   parameter int NUM_BANKS = 2,
   parameter int ID_BYTES  = 4,
   localparam int NREG     = 2 * NUM_BANKS * ID_BYTES,
   localparam int ADDR_W   = $clog2(NREG),
   localparam int HALF_W   = NUM_BANKS * ID_BYTES * BYTE_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [BYTE_W-1:0]   wdata,
   input  logic                init_req,
   input  logic                init_ack,
   output logic [BYTE_W-1:0]   rdata,
   output logic [HALF_W-1:0]   code_o,
   output logic [HALF_W-1:0]   mask_o
);
   logic [NREG*BYTE_W-1:0] regs_q;
   logic                   unlocked;

   assign unlocked = init_req && init_ack;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         regs_q <= '0;
      end else if (we && unlocked && (int'(addr) < NREG)) begin
         regs_q[int'(addr)*BYTE_W +: BYTE_W] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      if (int'(addr) < NREG) rdata = regs_q[int'(addr)*BYTE_W +: BYTE_W];
   end

   assign code_o = regs_q[HALF_W-1:0];
   assign mask_o = regs_q[2*HALF_W-1:HALF_W];

   // R2: outside initialization mode the register contents never move
   p_locked_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked |=> $stable(regs_q));
endmodule

// File: rtl/idscr_bank_match.sv
module idscr_bank_match
   import idscr_pkg::*;
#(
   parameter int ID_BYTES  = 4,
   parameter int STD_BYTES = 2,
   localparam int ID_W     = ID_BYTES * BYTE_W
) (
   input  logic [ID_W-1:0] id,
   input  logic            ide,
   input  logic [ID_W-1:0] code,
   input  logic [ID_W-1:0] mask,
   output logic            hit
);
   logic [ID_BYTES-1:0] byte_ok;
   logic [ID_BYTES-1:0] byte_used;

   for (genvar i = 0; i < ID_BYTES; i++) begin : g_byte
      logic [BYTE_W-1:0] idb;
      logic [BYTE_W-1:0] diff;
      assign idb  = id[(ID_BYTES-1-i)*BYTE_W +: BYTE_W];
      assign diff = (idb ^ code[i*BYTE_W +: BYTE_W]) & ~mask[i*BYTE_W +: BYTE_W];
      assign byte_ok[i] = (diff == '0);
      if (i < STD_BYTES) begin : g_std
         assign byte_used[i] = 1'b1;
      end else begin : g_ext
         assign byte_used[i] = ide;
      end
   end

   assign hit = &(byte_ok | ~byte_used);
endmodule

// File: rtl/idscr_rx_buf.sv
module idscr_rx_buf
   import idscr_pkg::*;
#(
   parameter int ID_W   = 32,
   parameter int BANK_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_eof,
   input  logic              rx_ide,
   input  logic [ID_W-1:0]   rx_id,
   input  logic              hit,
   input  logic [BANK_W-1:0] hit_bank,
   input  logic              host_ack,
   output logic [ID_W-1:0]   bg_id,
   output logic              bg_ide,
   output logic [ID_W-1:0]   fg_id,
   output logic              fg_ide,
   output logic [BANK_W-1:0] fg_bank,
   output logic              rx_ready,
   output logic              rx_overrun,
   output logic              dec_valid,
   output logic              dec_accept
);
   outcome_e outcome;
   logic     ready_eff;

   assign ready_eff = rx_ready && !host_ack;

   always_comb begin
      outcome = OUT_IDLE;
      if (rx_eof) begin
         if (!hit)           outcome = OUT_DROP;
         else if (ready_eff) outcome = OUT_OVERRUN;
         else                outcome = OUT_TAKE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bg_id      <= '0;
         bg_ide     <= 1'b0;
         fg_id      <= '0;
         fg_ide     <= 1'b0;
         fg_bank    <= '0;
         rx_ready   <= 1'b0;
         rx_overrun <= 1'b0;
         dec_valid  <= 1'b0;
         dec_accept <= 1'b0;
      end else begin
         dec_valid  <= rx_eof;
         dec_accept <= rx_eof && hit;
         if (rx_eof) begin
            bg_id  <= rx_id;
            bg_ide <= rx_ide;
         end
         case (outcome)
            OUT_TAKE: begin
               fg_id      <= rx_id;
               fg_ide     <= rx_ide;
               fg_bank    <= hit_bank;
               rx_ready   <= 1'b1;
               rx_overrun <= 1'b0;
            end
            OUT_OVERRUN: begin
               rx_overrun <= 1'b1;
            end
            default: begin
               rx_ready   <= ready_eff;
               rx_overrun <= rx_overrun && !host_ack;
            end
         endcase
      end
   end

   // R4: background slot always follows the last strobed frame
   p_bg_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_eof |=> (bg_id == $past(rx_id)));
   // R9: decision strobe one clock after end of frame
   p_dec_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_eof |=> dec_valid);
   p_dec_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_eof |=> !dec_valid);
   // R10: a dropped frame leaves ready and foreground alone
   p_miss_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_eof && !hit && !host_ack) |=> ($stable(rx_ready) && $stable(fg_id)));
   // R11: accepted frame while ready keeps foreground and flags overrun
   p_overrun_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_eof && hit && rx_ready && !host_ack) |=> ($stable(fg_id) && rx_overrun));
   p_ovr_needs_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rx_overrun |-> rx_ready);
   // R12: acknowledge clears, coincident accept wins
   p_ack_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (host_ack && !(rx_eof && hit)) |=> (!rx_ready && !rx_overrun));
   p_ack_take_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_eof && hit && (!rx_ready || host_ack)) |=>
         (rx_ready && !rx_overrun && (fg_id == $past(rx_id))));
endmodule

// File: rtl/can_id_screen.sv
module can_id_screen
   import idscr_pkg::*;
#(
   parameter int NUM_BANKS = 2,
   parameter int ID_BYTES  = 4,
   parameter int STD_BYTES = 2,
   localparam int ID_W     = ID_BYTES * BYTE_W,
   localparam int NREG     = 2 * NUM_BANKS * ID_BYTES,
   localparam int ADDR_W   = $clog2(NREG),
   localparam int BANK_W   = $clog2(NUM_BANKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [BYTE_W-1:0] cfg_wdata,
   output logic [BYTE_W-1:0] cfg_rdata,
   input  logic              init_req,
   input  logic              init_ack,
   input  logic              rx_eof,
   input  logic              rx_ide,
   input  logic [ID_W-1:0]   rx_id,
   input  logic              host_ack,
   output logic [ID_W-1:0]   bg_id,
   output logic              bg_ide,
   output logic [ID_W-1:0]   fg_id,
   output logic              fg_ide,
   output logic [BANK_W-1:0] fg_bank,
   output logic              rx_ready,
   output logic              rx_overrun,
   output logic              dec_valid,
   output logic              dec_accept
);
   if (NUM_BANKS < 2) begin : g_bad_banks
      $error("can_id_screen: NUM_BANKS must be at least 2");
   end
   if (STD_BYTES < 1 || STD_BYTES > ID_BYTES) begin : g_bad_std
      $error("can_id_screen: STD_BYTES must lie in 1..ID_BYTES");
   end

   logic [NUM_BANKS*ID_W-1:0] code_all;
   logic [NUM_BANKS*ID_W-1:0] mask_all;
   logic [NUM_BANKS-1:0]      bank_hit;
   logic                      hit;
   logic [BANK_W-1:0]         hit_bank;

   idscr_regs #(
      .NUM_BANKS (NUM_BANKS),
      .ID_BYTES  (ID_BYTES)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (cfg_we),
      .addr     (cfg_addr),
      .wdata    (cfg_wdata),
      .init_req (init_req),
      .init_ack (init_ack),
      .rdata    (cfg_rdata),
      .code_o   (code_all),
      .mask_o   (mask_all)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      idscr_bank_match #(
         .ID_BYTES  (ID_BYTES),
         .STD_BYTES (STD_BYTES)
      ) u_match (
         .id   (rx_id),
         .ide  (rx_ide),
         .code (code_all[b*ID_W +: ID_W]),
         .mask (mask_all[b*ID_W +: ID_W]),
         .hit  (bank_hit[b])
      );
   end

   // lowest-numbered matching bank wins
   always_comb begin
      hit      = 1'b0;
      hit_bank = '0;
      for (int b = NUM_BANKS - 1; b >= 0; b--) begin
         if (bank_hit[b]) begin
            hit      = 1'b1;
            hit_bank = BANK_W'(b);
         end
      end
   end

   // R8: the reported bank really matched
   p_bank_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_eof && hit) |-> bank_hit[hit_bank]);

   idscr_rx_buf #(
      .ID_W   (ID_W),
      .BANK_W (BANK_W)
   ) u_buf (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_eof     (rx_eof),
      .rx_ide     (rx_ide),
      .rx_id      (rx_id),
      .hit        (hit),
      .hit_bank   (hit_bank),
      .host_ack   (host_ack),
      .bg_id      (bg_id),
      .bg_ide     (bg_ide),
      .fg_id      (fg_id),
      .fg_ide     (fg_ide),
      .fg_bank    (fg_bank),
      .rx_ready   (rx_ready),
      .rx_overrun (rx_overrun),
      .dec_valid  (dec_valid),
      .dec_accept (dec_accept)
   );
endmodule

// File: tb/can_id_screen_test.sv
module can_id_screen_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic [3:0]  cfg_addr;
   logic [7:0]  cfg_wdata;
   logic [7:0]  cfg_rdata;
   logic        init_req, init_ack;
   logic        rx_eof, rx_ide;
   logic [31:0] rx_id;
   logic        host_ack;
   logic [31:0] bg_id, fg_id;
   logic        bg_ide, fg_ide;
   logic [0:0]  fg_bank;
   logic        rx_ready, rx_overrun, dec_valid, dec_accept;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   can_id_screen uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .init_req(init_req),
      .init_ack(init_ack), .rx_eof(rx_eof), .rx_ide(rx_ide), .rx_id(rx_id),
      .host_ack(host_ack), .bg_id(bg_id), .bg_ide(bg_ide), .fg_id(fg_id),
      .fg_ide(fg_ide), .fg_bank(fg_bank), .rx_ready(rx_ready),
      .rx_overrun(rx_overrun), .dec_valid(dec_valid), .dec_accept(dec_accept)
   );

   typedef struct packed {
      logic        ide;
      logic [31:0] id;
      logic        acc;
      logic        bnk;
   } vec_t;

   // bank0 code 12 34 56 78 mask 00 00 00 0F ; bank1 code AB C0 00 00 mask 00 1F FF FF
   localparam int NVEC = 11;
   localparam vec_t VECS [NVEC] = '{
      '{1'b1, 32'h12345678, 1'b1, 1'b0},
      '{1'b1, 32'h1234567F, 1'b1, 1'b0},
      '{1'b1, 32'h12345688, 1'b0, 1'b0},
      '{1'b1, 32'hABDF1234, 1'b1, 1'b1},
      '{1'b1, 32'hABE00000, 1'b0, 1'b0},
      '{1'b1, 32'h1234FFFF, 1'b0, 1'b0},
      '{1'b0, 32'h1234FFFF, 1'b1, 1'b0},
      '{1'b0, 32'h12350000, 1'b0, 1'b0},
      '{1'b0, 32'hABC0AAAA, 1'b1, 1'b1},
      '{1'b1, 32'h12355678, 1'b0, 1'b0},
      '{1'b0, 32'h12340000, 1'b1, 1'b0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
      cfg_addr = a;
      #1;
      chk(tag, {24'h0, cfg_rdata}, {24'h0, exp});
   endtask

   task automatic frame(input logic ide, input logic [31:0] id, input logic ack);
      @(negedge clk);
      rx_ide = ide; rx_id = id; rx_eof = 1'b1; host_ack = ack;
      @(negedge clk);
      rx_eof = 1'b0; host_ack = 1'b0;
   endtask

   task automatic do_ack();
      @(negedge clk);
      host_ack = 1'b1;
      @(negedge clk);
      host_ack = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R9 watchdog: actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
      init_req = 1'b0; init_ack = 1'b0; rx_eof = 1'b0; rx_ide = 1'b0;
      rx_id = '0; host_ack = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 ready", {31'h0, rx_ready}, 32'h0);
      chk("R1 overrun", {31'h0, rx_overrun}, 32'h0);
      chk("R1 dec_valid", {31'h0, dec_valid}, 32'h0);
      for (int a = 0; a < 16; a++) rd_chk("R1 reg", 4'(a), 8'h00);

      // program filters in initialization mode
      init_req = 1'b1; init_ack = 1'b1;
      wr(4'd0, 8'h12); wr(4'd1, 8'h34); wr(4'd2, 8'h56); wr(4'd3, 8'h78);
      wr(4'd4, 8'hAB); wr(4'd5, 8'hC0); wr(4'd6, 8'h00); wr(4'd7, 8'h00);
      wr(4'd8, 8'h00); wr(4'd9, 8'h00); wr(4'd10, 8'h00); wr(4'd11, 8'h0F);
      wr(4'd12, 8'h00); wr(4'd13, 8'h1F); wr(4'd14, 8'hFF); wr(4'd15, 8'hFF);
      rd_chk("R3 code0", 4'd0, 8'h12);
      rd_chk("R3 code5", 4'd5, 8'hC0);
      rd_chk("R3 mask11", 4'd11, 8'h0F);

      // R2 writes outside initialization mode are ignored
      init_ack = 1'b0;
      wr(4'd0, 8'hFF); wr(4'd8, 8'hFF);
      init_req = 1'b0; init_ack = 1'b1;
      wr(4'd1, 8'hEE);
      init_ack = 1'b0;
      rd_chk("R2 code0 locked", 4'd0, 8'h12);
      rd_chk("R2 mask8 locked", 4'd8, 8'h00);
      rd_chk("R2 code1 locked", 4'd1, 8'h34);
      rd_chk("R3 read while locked", 4'd13, 8'h1F);

      // vector walk
      for (int v = 0; v < NVEC; v++) begin
         frame(VECS[v].ide, VECS[v].id, 1'b0);
         chk("R9 dec_valid", {31'h0, dec_valid}, 32'h1);
         chk(VECS[v].ide ? "R6 R5 accept" : "R7 R5 accept",
             {31'h0, dec_accept}, {31'h0, VECS[v].acc});
         chk("R4 bg_id", bg_id, VECS[v].id);
         chk("R10 ready", {31'h0, rx_ready}, {31'h0, VECS[v].acc});
         if (VECS[v].acc) begin
            chk("R10 fg_id", fg_id, VECS[v].id);
            chk("R8 bank", {31'h0, fg_bank}, {31'h0, VECS[v].bnk});
         end
         do_ack();
         chk("R9 dec_valid low", {31'h0, dec_valid}, 32'h0);
         chk("R12 ready cleared", {31'h0, rx_ready}, 32'h0);
      end

      // R11 overrun
      frame(1'b1, 32'h12345678, 1'b0);
      frame(1'b1, 32'h1234567A, 1'b0);
      chk("R11 fg kept", fg_id, 32'h12345678);
      chk("R11 overrun", {31'h0, rx_overrun}, 32'h1);
      chk("R11 ready held", {31'h0, rx_ready}, 32'h1);
      chk("R4 bg after overrun", bg_id, 32'h1234567A);
      frame(1'b1, 32'h99999999, 1'b0);
      chk("R10 drop keeps fg", fg_id, 32'h12345678);
      chk("R11 overrun sticky", {31'h0, rx_overrun}, 32'h1);

      // R12 acknowledge coincident with an accepted frame
      frame(1'b1, 32'hABC01111, 1'b1);
      chk("R12 ready stays", {31'h0, rx_ready}, 32'h1);
      chk("R12 overrun cleared", {31'h0, rx_overrun}, 32'h0);
      chk("R12 fg loaded", fg_id, 32'hABC01111);
      chk("R12 bank", {31'h0, fg_bank}, 32'h1);
      do_ack();
      chk("R12 ack clears", {31'h0, rx_ready}, 32'h0);

      // R8 tie between banks: bank1 mask all ones
      init_req = 1'b1; init_ack = 1'b1;
      wr(4'd12, 8'hFF); wr(4'd13, 8'hFF);
      init_req = 1'b0; init_ack = 1'b0;
      frame(1'b1, 32'h12345678, 1'b0);
      chk("R8 tie accept", {31'h0, dec_accept}, 32'h1);
      chk("R8 tie bank0", {31'h0, fg_bank}, 32'h0);
      do_ack();
      frame(1'b1, 32'h99999999, 1'b0);
      chk("R8 bank1 only", {31'h0, fg_bank}, 32'h1);
      chk("R10 ide stored", {31'h0, fg_ide}, 32'h1);
      do_ack();

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule